// File: doc/BRIEF.md
# Parallel 8080-Style LCD Write Engine

This block feeds a command-mode LCD panel through a parallel bus with an active-low chip select and an active-low write strobe. Each pixel is taken from an input stream with a valid/ready handshake. It is then placed on the bus data pins for one write cycle. The cycle is built from programmable counts: a select setup before the first pixel of a frame, then for each pixel a write setup, a strobe-low active time and a strobe-high hold time. The select line is released after the last pixel of the frame.

A frame can be started in two ways. Software can issue a trigger command through the register port. The panel's tearing-effect (TE) line can also start a frame, and in per-pulse mode it may do so only while a count of pending window updates is above zero. A start request that arrives while a frame is in flight is dropped. When the frame ends the block raises an interrupt, and that interrupt stays set until software acknowledges it.

The register port takes write-only words. The timing word at address 0 holds the select setup count in bits 19:16, the write setup count in bits 15:12, the active count in bits 11:8, the hold count in bits 7:4 and the interface enable in bit 0. After reset these counts are 0, 0, 1 and 0, and the interface is disabled. The trigger word at address 1 has five bits that matter:
- bit 0 is the trigger-mode bit;
- bit 1 is the software start command;
- bit 3 enables TE starts;
- bit 4 masks TE starts;
- bit 31 selects per-pulse mode.

Address 2 holds the frame length minus one. Writing 1 in bit 0 at address 3 adds one pending update. Writing 1 in bit 0 at address 4 acknowledges the interrupt.

Top module: `pbus_lcd_writer`

## Requirements
- R1: After reset, cs_n and wr_n are high, and irq and px_ready are low.
- R2: A write to address 1 with bit 1 and bit 0 both set starts a frame, but only if bit 0 of the timing word is 1. If either trigger bit is clear, or the interface is disabled, no frame starts.
- R3: With px_valid held high, the cycle timing is as follows. From cs_n falling to the first wr_n low takes select setup + write setup + 1 cycles. Each wr_n low lasts the active count. Between two strobes, wr_n stays high for hold + 1 + write setup cycles.
- R4: A count of zero skips its phase, except the active phase: an active count of 0 gives a strobe one cycle long.
- R5: A frame writes (address-2 value + 1) pixels. px_ready is asserted once per pixel. bus_data shows each pixel for its whole strobe, and the pixels come out in stream order.
- R6: cs_n rises exactly hold-count cycles after the last wr_n rise. irq rises in the same cycle as cs_n.
- R7: irq stays high until a write to address 4 with bit 0 set. A write there with bit 0 clear leaves irq unchanged.
- R8: Software or TE start requests made while a frame is in flight are ignored, and they do not consume a pending update.
- R9: When bit 31 is set, a TE rising edge starts a frame only if the pending count is non-zero. Each such start takes one from the count, and the count never goes below zero.
- R10: A TE edge starts nothing when bit 3 is clear or bit 4 is set.
- R11: When bit 31 is clear (and bit 3 is set, bit 4 clear), every TE rising edge seen while idle starts a frame, whatever the pending count.
- R12: While px_valid is low at a pixel boundary, the engine waits with cs_n low, wr_n high and px_ready low. Once px_valid rises, the strobe follows write setup + 1 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| px_valid | input | 1 | Pixel stream valid |
| px_data | input | DATA_W | Pixel stream data |
| px_ready | output | 1 | Pixel taken this cycle |
| cs_n | output | 1 | Panel chip select, active low |
| wr_n | output | 1 | Panel write strobe, active low |
| bus_data | output | DATA_W | Panel data bus |
| te_in | input | 1 | Tearing-effect input from the panel |
| irq | output | 1 | Frame-done interrupt |

## Verification
A software start takes effect at the clock edge that takes the register write, so cs_n is already low at the next falling edge. From that point every phase length is counted one cycle per falling-edge sample: select setup, write setup, strobe width, hold, and the tail before cs_n rises. TE passes through a three-stage synchronizer, so a frame starts on the third rising edge after te_in goes high. For this reason the TE checks hold te_in high long enough for that, and then count cs_n falling edges rather than exact cycles. The interrupt is set and cleared at the same edge as the cs_n rise or the acknowledge write, so it is sampled at the falling edge that follows.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
  localparam int CNT_W  = 4;
  localparam int ADDR_W = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] A_TIMING = 3'd0;
  localparam logic [ADDR_W-1:0] A_TRIG   = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLEN   = 3'd2;
  localparam logic [ADDR_W-1:0] A_UPDATE = 3'd3;
  localparam logic [ADDR_W-1:0] A_IRQACK = 3'd4;

  // trigger word bits
  localparam int TB_MODE   = 0;
  localparam int TB_CMD    = 1;
  localparam int TB_HWEN   = 3;
  localparam int TB_HWMASK = 4;
  localparam int TB_PERTE  = 31;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CSS, PH_FETCH, PH_WSU, PH_ACT, PH_HOLD
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] cs_setup;
    logic [CNT_W-1:0] wr_setup;
    logic [CNT_W-1:0] wr_active;
    logic [CNT_W-1:0] wr_hold;
  } wtiming_t;

  localparam wtiming_t TIMING_DEFAULT = '{cs_setup: '0, wr_setup: '0,
                                          wr_active: CNT_W'(1), wr_hold: '0};

  // strobe-low phase is never shorter than one cycle
  function automatic logic [CNT_W-1:0] strobe_len(input logic [CNT_W-1:0] a);
    return (a == '0) ? CNT_W'(1) : a;
  endfunction
endpackage

// File: rtl/lcdw_regs.sv
module lcdw_regs import lcdw_pkg::*; #(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output wtiming_t          tim,
  output logic              if_en,
  output logic              hw_en,
  output logic              hw_mask,
  output logic              per_te,
  output logic [LEN_W-1:0]  flen,
  output logic              sw_go,
  output logic              upd_inc,
  output logic              irq_ack
);
  logic sel_tim, sel_trig, sel_flen;
  logic unused_wdata;

  assign sel_tim  = reg_wr && (reg_addr == A_TIMING);
  assign sel_trig = reg_wr && (reg_addr == A_TRIG);
  assign sel_flen = reg_wr && (reg_addr == A_FLEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tim     <= TIMING_DEFAULT;
      if_en   <= 1'b0;
      hw_en   <= 1'b0;
      hw_mask <= 1'b0;
      per_te  <= 1'b0;
      flen    <= '0;
    end else begin
      if (sel_tim) begin
        tim.cs_setup  <= reg_wdata[19:16];
        tim.wr_setup  <= reg_wdata[15:12];
        tim.wr_active <= reg_wdata[11:8];
        tim.wr_hold   <= reg_wdata[7:4];
        if_en         <= reg_wdata[0];
      end
      if (sel_trig) begin
        hw_en   <= reg_wdata[TB_HWEN];
        hw_mask <= reg_wdata[TB_HWMASK];
        per_te  <= reg_wdata[TB_PERTE];
      end
      if (sel_flen) flen <= reg_wdata[LEN_W-1:0];
    end
  end

  // single-cycle command pulses taken straight from the write
  assign sw_go   = sel_trig && reg_wdata[TB_CMD] && reg_wdata[TB_MODE];
  assign upd_inc = reg_wr && (reg_addr == A_UPDATE) && reg_wdata[0];
  assign irq_ack = reg_wr && (reg_addr == A_IRQACK) && reg_wdata[0];

  assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/lcdw_trig.sv
module lcdw_trig #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              te_in,
  input  logic              if_en,
  input  logic              hw_en,
  input  logic              hw_mask,
  input  logic              per_te,
  input  logic              sw_go,
  input  logic              upd_inc,
  input  logic              busy,
  output logic              start,
  output logic [PEND_W-1:0] pend_cnt
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [2:0] te_sh;
  logic       te_rise, te_go, consume;

  function automatic logic [PEND_W-1:0] pend_step(input logic [PEND_W-1:0] c,
                                                  input logic inc, input logic dec);
    if (inc && !dec && c != PEND_MAX) return c + 1'b1;
    if (dec && !inc && c != '0)       return c - 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) te_sh <= '0;
    else        te_sh <= {te_sh[1:0], te_in};
  end

  assign te_rise = te_sh[1] && !te_sh[2];
  assign te_go   = te_rise && hw_en && !hw_mask && (!per_te || pend_cnt != '0);
  assign start   = if_en && !busy && (sw_go || te_go);
  // a TE start in per-pulse mode uses up one pending update
  assign consume = start && !sw_go && te_go && per_te;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_cnt <= '0;
    else        pend_cnt <= pend_step(pend_cnt, upd_inc, consume);
  end
endmodule

// File: rtl/lcdw_seq.sv
module lcdw_seq import lcdw_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  wtiming_t          tim,
  input  logic [LEN_W-1:0]  flen,
  input  logic              px_valid,
  input  logic [DATA_W-1:0] px_data,
  output logic              px_ready,
  output logic              cs_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] bus_data,
  output logic              busy,
  output logic              frame_done
);
  phase_e           ph, ph_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [LEN_W-1:0] rem;
  logic             last_px;
  logic             fetch_ok, cnt_end;
  logic [DATA_W-1:0] dreg;

  assign fetch_ok = (ph == PH_FETCH) && px_valid;
  assign cnt_end  = (cnt == CNT_W'(1));

  always_comb begin
    ph_nx      = ph;
    cnt_nx     = (cnt != '0) ? cnt - 1'b1 : cnt;
    frame_done = 1'b0;
    unique case (ph)
      PH_IDLE: if (start) begin
        if (tim.cs_setup != '0) begin ph_nx = PH_CSS; cnt_nx = tim.cs_setup; end
        else ph_nx = PH_FETCH;
      end
      PH_CSS: if (cnt_end) ph_nx = PH_FETCH;
      PH_FETCH: if (px_valid) begin
        if (tim.wr_setup != '0) begin ph_nx = PH_WSU; cnt_nx = tim.wr_setup; end
        else begin ph_nx = PH_ACT; cnt_nx = strobe_len(tim.wr_active); end
      end
      PH_WSU: if (cnt_end) begin
        ph_nx  = PH_ACT;
        cnt_nx = strobe_len(tim.wr_active);
      end
      PH_ACT: if (cnt_end) begin
        if (tim.wr_hold != '0) begin ph_nx = PH_HOLD; cnt_nx = tim.wr_hold; end
        else if (last_px) begin ph_nx = PH_IDLE; frame_done = 1'b1; end
        else ph_nx = PH_FETCH;
      end
      PH_HOLD: if (cnt_end) begin
        if (last_px) begin ph_nx = PH_IDLE; frame_done = 1'b1; end
        else ph_nx = PH_FETCH;
      end
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      rem     <= '0;
      last_px <= 1'b0;
      dreg    <= '0;
    end else begin
      ph  <= ph_nx;
      cnt <= cnt_nx;
      if (ph == PH_IDLE && start) rem <= flen;
      if (fetch_ok) begin
        dreg    <= px_data;
        last_px <= (rem == '0);
        if (rem != '0) rem <= rem - 1'b1;
      end
    end
  end

  assign busy     = (ph != PH_IDLE);
  assign cs_n     = !busy;
  assign wr_n     = (ph != PH_ACT);
  assign px_ready = fetch_ok;
  assign bus_data = dreg;
endmodule

// File: rtl/pbus_lcd_writer.sv
module pbus_lcd_writer import lcdw_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 12,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              px_valid,
  input  logic [DATA_W-1:0] px_data,
  output logic              px_ready,
  output logic              cs_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] bus_data,
  input  logic              te_in,
  output logic              irq
);
  wtiming_t          tim;
  logic              if_en, hw_en, hw_mask, per_te;
  logic [LEN_W-1:0]  flen;
  logic              sw_go, upd_inc, irq_ack;
  logic              start, busy, frame_done;
  logic [PEND_W-1:0] pend_cnt;

  lcdw_regs #(.LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tim(tim), .if_en(if_en), .hw_en(hw_en),
    .hw_mask(hw_mask), .per_te(per_te), .flen(flen), .sw_go(sw_go),
    .upd_inc(upd_inc), .irq_ack(irq_ack)
  );

  lcdw_trig #(.PEND_W(PEND_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .te_in(te_in), .if_en(if_en), .hw_en(hw_en),
    .hw_mask(hw_mask), .per_te(per_te), .sw_go(sw_go), .upd_inc(upd_inc),
    .busy(busy), .start(start), .pend_cnt(pend_cnt)
  );

  lcdw_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tim(tim), .flen(flen),
    .px_valid(px_valid), .px_data(px_data), .px_ready(px_ready),
    .cs_n(cs_n), .wr_n(wr_n), .bus_data(bus_data), .busy(busy),
    .frame_done(frame_done)
  );

  // done wins over a same-cycle acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n)          irq <= 1'b0;
    else if (frame_done) irq <= 1'b1;
    else if (irq_ack)    irq <= 1'b0;
  end
endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker #(
  parameter int DATA_W = 16,
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              wr_n,
  input logic              px_ready,
  input logic              irq,
  input logic              frame_done,
  input logic              upd_inc,
  input logic              irq_ack,
  input logic [DATA_W-1:0] bus_data,
  input logic [PEND_W-1:0] pend_cnt
);
  // R5
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);
  // R5
  strobe_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> (wr_n || $stable(bus_data)));
  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (cs_n && irq));
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  // R9
  pend_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == '0 && !upd_inc) |=> (pend_cnt == '0));
  // R8
  busy_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !upd_inc) |=> $stable(pend_cnt));
  // R12
  ready_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_ready |-> (!cs_n && wr_n));
endmodule

bind pbus_lcd_writer lcdw_checker #(.DATA_W(DATA_W), .PEND_W(PEND_W)) u_chk (.*);

// File: tb/sim_pbus_lcd_writer.sv
`timescale 1ns/1ps
module sim_pbus_lcd_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        px_valid = 1'b1;
  logic [15:0] px_data = 16'h1000;
  logic        px_ready, cs_n, wr_n, irq;
  logic [15:0] bus_data;
  logic        te_in = 1'b0;

  int n_chk = 0, n_fail = 0;
  int cs_falls = 0, wr_falls = 0;
  bit took = 0, prev_cs = 1, prev_wr_m = 1, done_flag = 0;

  int m_found, m_lead, m_tail, m_np, m_rdy, m_irq;
  int m_low[16];
  int m_high[16];
  logic [15:0] m_dat[16];

  always #5 clk = ~clk;

  pbus_lcd_writer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .px_valid(px_valid), .px_data(px_data),
    .px_ready(px_ready), .cs_n(cs_n), .wr_n(wr_n), .bus_data(bus_data),
    .te_in(te_in), .irq(irq)
  );

  // pixel source: advance one word after each accepted pixel
  initial forever begin
    @(negedge clk);
    if (took) px_data = px_data + 16'd1;
    took = px_ready;
  end

  // edge counters on the panel pins
  initial forever begin
    @(negedge clk);
    if (prev_cs && !cs_n) cs_falls++;
    if (prev_wr_m && !wr_n) wr_falls++;
    prev_cs = cs_n;
    prev_wr_m = wr_n;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tim_w(input int css, input int wsu, input int act,
                                        input int hold, input bit en);
    return {12'b0, 4'(css), 4'(wsu), 4'(act), 4'(hold), 3'b0, en};
  endfunction

  function automatic logic [31:0] trig_w(input bit perte, input bit mask, input bit hwen,
                                         input bit cmd, input bit mode);
    return {perte, 26'b0, mask, hwen, 1'b0, cmd, mode};
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ack_irq();
    wr_reg(3'd4, 32'd1);
  endtask

  task automatic te_pulse();
    @(negedge clk); te_in = 1'b1;
    repeat (3) @(negedge clk);
    te_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    int g;
    g = 0;
    while (!cs_n && g < 3000) begin @(negedge clk); g++; end
    if (g >= 3000) check("R5", "frame never ended", 0, 1);
  endtask

  task automatic measure_frame();
    int run, guard;
    bit pw;
    m_found = 0; m_np = 0; m_lead = 0; m_tail = 0; m_rdy = 0; m_irq = 0;
    for (int i = 0; i < 80; i++) begin
      if (!cs_n) begin m_found = 1; break; end
      @(negedge clk);
    end
    if (m_found == 0) return;
    run = 0; pw = 1; guard = 0;
    while (!cs_n && guard < 4000) begin
      if (px_ready) m_rdy++;
      if (!wr_n) begin
        if (pw) begin
          if (m_np == 0) m_lead = run;
          else if (m_np <= 16) m_high[m_np-1] = run;
          if (m_np < 16) begin m_dat[m_np] = bus_data; m_low[m_np] = 0; end
          m_np++;
        end
        if (m_np <= 16) m_low[m_np-1]++;
      end else begin
        if (!pw) run = 0;
        run++;
      end
      pw = wr_n;
      guard++;
      @(negedge clk);
    end
    m_tail = pw ? run : 0;
    m_irq = irq;
  endtask

  task automatic check_frame(input string rq, input int e_lead, input int e_low,
                             input int e_high, input int e_tail, input int e_np,
                             input logic [15:0] base);
    check(rq, "frame started", m_found, 1);
    check(rq, "lead cycles", m_lead, e_lead);
    check("R5", "pixel count", m_np, e_np);
    check("R5", "ready count", m_rdy, e_np);
    for (int k = 0; k < e_np && k < 16; k++) begin
      check(rq, "strobe width", m_low[k], e_low);
      check("R5", "pixel data", m_dat[k], base + 16'(k));
      if (k > 0) check(rq, "gap cycles", m_high[k-1], e_high);
    end
    check("R6", "tail cycles", m_tail, e_tail);
    check("R6", "irq at release", m_irq, 1);
  endtask

  task automatic t_reset();
    check("R1", "cs_n", cs_n, 1);
    check("R1", "wr_n", wr_n, 1);
    check("R1", "irq", irq, 0);
    check("R1", "px_ready", px_ready, 0);
  endtask

  task automatic run_sw(input string rq, input int css, input int wsu, input int act,
                        input int hold, input int len);
    logic [15:0] base;
    int ea;
    wr_reg(3'd0, tim_w(css, wsu, act, hold, 1'b1));
    wr_reg(3'd2, 32'(len));
    base = px_data;
    wr_reg(3'd1, trig_w(0, 0, 0, 1, 1));
    measure_frame();
    ea = (act == 0) ? 1 : act;
    check_frame(rq, css + wsu + 1, ea, hold + 1 + wsu, hold, len + 1, base);
  endtask

  task automatic t_sw_patterns();
    run_sw("R3", 2, 1, 3, 2, 2);
    ack_irq();
    run_sw("R3", 0, 0, 2, 1, 1);
    ack_irq();
    run_sw("R3", 15, 15, 15, 15, 0);
    ack_irq();
  endtask

  task automatic t_zero();
    run_sw("R4", 0, 0, 0, 0, 3);
  endtask

  task automatic t_irq();
    repeat (10) @(negedge clk);
    check("R7", "irq held", irq, 1);
    wr_reg(3'd4, 32'd0);
    check("R7", "irq after ack of 0", irq, 1);
    wr_reg(3'd4, 32'd1);
    check("R7", "irq after ack of 1", irq, 0);
  endtask

  task automatic t_gate();
    int c0;
    logic [15:0] base;
    wr_reg(3'd2, 32'd1);
    wr_reg(3'd0, tim_w(1, 0, 1, 0, 1'b0));
    c0 = cs_falls;
    wr_reg(3'd1, trig_w(0, 0, 0, 1, 1));
    repeat (20) @(negedge clk);
    check("R2", "start with interface off", cs_falls - c0, 0);
    wr_reg(3'd0, tim_w(1, 0, 1, 0, 1'b1));
    wr_reg(3'd1, trig_w(0, 0, 0, 1, 0));
    repeat (20) @(negedge clk);
    check("R2", "command without mode bit", cs_falls - c0, 0);
    base = px_data;
    wr_reg(3'd1, trig_w(0, 0, 0, 1, 1));
    measure_frame();
    check_frame("R2", 2, 1, 1, 0, 2, base);
    ack_irq();
  endtask

  task automatic t_stall();
    int n;
    logic [15:0] base;
    bit ok;
    wr_reg(3'd0, tim_w(1, 2, 1, 0, 1'b1));
    wr_reg(3'd2, 32'd0);
    @(negedge clk); px_valid = 1'b0;
    base = px_data;
    wr_reg(3'd1, trig_w(0, 0, 0, 1, 1));
    ok = 1;
    for (int i = 0; i < 6; i++) begin
      if (cs_n || !wr_n || px_ready) ok = 0;
      @(negedge clk);
    end
    check("R12", "waiting with select held", ok, 1);
    px_valid = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); n++;
      if (!wr_n) break;
    end
    check("R12", "strobe delay after valid", n, 3);
    check("R12", "stalled pixel data", bus_data, base);
    wait_idle();
    ack_irq();
  endtask

  task automatic t_busy();
    int c0, w0;
    wr_reg(3'd0, tim_w(0, 0, 8, 0, 1'b1));
    wr_reg(3'd2, 32'd5);
    wr_reg(3'd3, 32'd1);
    c0 = cs_falls; w0 = wr_falls;
    wr_reg(3'd1, trig_w(1, 0, 1, 1, 1));
    repeat (8) @(negedge clk);
    wr_reg(3'd1, trig_w(1, 0, 1, 1, 1));
    te_pulse();
    check("R8", "still in frame", cs_n, 0);
    wait_idle();
    check("R8", "one select period", cs_falls - c0, 1);
    check("R8", "strobes in frame", wr_falls - w0, 6);
    ack_irq();
    repeat (20) @(negedge clk);
    check("R8", "no late restart", cs_falls - c0, 1);
    te_pulse();
    wait_idle();
    check("R8", "pending update kept", cs_falls - c0, 2);
    ack_irq();
  endtask

  task automatic t_te_pend();
    int c0;
    wr_reg(3'd0, tim_w(0, 0, 8, 0, 1'b1));
    wr_reg(3'd2, 32'd3);
    wr_reg(3'd1, trig_w(1, 0, 1, 0, 0));
    c0 = cs_falls;
    te_pulse(); repeat (20) @(negedge clk);
    check("R9", "TE with nothing pending", cs_falls - c0, 0);
    wr_reg(3'd3, 32'd1);
    wr_reg(3'd3, 32'd1);
    te_pulse(); wait_idle(); ack_irq();
    check("R9", "first pending TE", cs_falls - c0, 1);
    te_pulse(); wait_idle(); ack_irq();
    check("R9", "second pending TE", cs_falls - c0, 2);
    te_pulse(); repeat (20) @(negedge clk);
    check("R9", "count exhausted", cs_falls - c0, 2);
  endtask

  task automatic t_te_mask();
    int c0;
    wr_reg(3'd3, 32'd1);
    c0 = cs_falls;
    wr_reg(3'd1, trig_w(1, 1, 1, 0, 0));
    te_pulse(); repeat (20) @(negedge clk);
    check("R10", "masked TE", cs_falls - c0, 0);
    wr_reg(3'd1, trig_w(1, 0, 0, 0, 0));
    te_pulse(); repeat (20) @(negedge clk);
    check("R10", "TE with enable clear", cs_falls - c0, 0);
    wr_reg(3'd1, trig_w(1, 0, 1, 0, 0));
    te_pulse(); wait_idle(); ack_irq();
    check("R10", "TE once unmasked", cs_falls - c0, 1);
  endtask

  task automatic t_te_free();
    int c0;
    wr_reg(3'd1, trig_w(0, 0, 1, 0, 0));
    c0 = cs_falls;
    te_pulse(); wait_idle(); ack_irq();
    check("R11", "free-running TE 1", cs_falls - c0, 1);
    te_pulse(); wait_idle(); ack_irq();
    check("R11", "free-running TE 2", cs_falls - c0, 2);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sw_patterns();
    t_zero();
    t_irq();
    t_gate();
    t_stall();
    t_busy();
    t_te_pend();
    t_te_mask();
    t_te_free();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule